// File: doc/BRIEF.md
# Banked Interrupt Cause Controller

This block gathers event pulses from three independent sources (receive, transmit and miscellaneous) into three cause banks and drives one level-sensitive host interrupt line. Each bank latches incoming events into a cause register. The bank has its own mask, changed through separate set-bits and clear-bits write registers and readable as a plain value. A per-bank mode register chooses whether software clears the cause register by reading it or by writing ones to it.

A summary register keeps one bit per bank. That bit is set whenever the bank holds a pending bit that its mask does not block, and a read of the summary register clears it. A software mask on the summary bits decides which of them reach the interrupt line. Software reaches every register through a single-cycle read/write port. Read data is combinational from the current register state, and writes and read side effects take effect at the next clock edge.

The receive bank uses bit 0 for receive-done and bit 1 for the buffer high-threshold warning. The transmit bank uses bits 0 to 24 for per-ring completions and bit 25 for overall transmit-done. The miscellaneous bank uses bit 0 for firmware ready, bit 1 for a mailbox event and bit 2 for a firmware error.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After reset every cause register and the summary register read 0, every bank mask and the summary mask read 0xFFFFFFFF, every mode register reads 0 (write-one-to-clear) and `irq_o` is low.
- R2: An event bit that is high at a clock edge sets the matching cause bit at that edge. The bit stays set until it is cleared, whether or not the bank mask covers it.
- R3: A write to mask-set (offset 1) ORs the write data into the bank mask. A write to mask-clear (offset 2) clears the mask bits that are one in the write data. Mask-value (offset 3) reads the current mask.
- R4: In write-one-to-clear mode (any mode value other than all ones), a write to the cause register (offset 0) clears the bits given as ones. Reading the cause register leaves it unchanged.
- R5: With mode (offset 4) set to 0xFFFFFFFF, a read of the cause register returns its value and clears the whole register at that edge. A write to the cause register has no effect.
- R6: An event arriving at the same edge as a clearing read or a write-one-to-clear on that bit leaves the bit set.
- R7: Summary bit 0 (receive), bit 1 (transmit) and bit 2 (miscellaneous) is set at the edge after its bank holds a cause bit whose mask bit is 0.
- R8: Reading the summary register (address 0x18) returns its value and clears it. A bit whose bank is still pending at that edge stays set.
- R9: `irq_o` is high exactly while some summary bit is set and its summary mask bit (address 0x19) is 0. Writing 0xFFFFFFF8 to the summary mask enables all three bits, and writing 0xFFFFFFFF blocks them all.
- R10: Events land at fixed bit positions. Receive: done at bit 0, high-threshold at bit 1. Transmit: rings at bits 0 to 24, done at bit 25. Miscellaneous: ready at bit 0, mailbox at bit 1, error at bit 2.
- R11: Word addresses are formed as bank base plus offset, with bases receive 0x00, transmit 0x08, miscellaneous 0x10 and summary 0x18. Reads of unmapped addresses return 0, and read data shows the value held before any clearing the read causes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_en_i | input | 1 | Read strobe for the register port |
| wr_en_i | input | 1 | Write strobe for the register port |
| addr_i | input | 5 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| rx_evt_i | input | 32 | Receive bank event bits |
| tx_evt_i | input | 32 | Transmit bank event bits |
| misc_evt_i | input | 32 | Miscellaneous bank event bits |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
The properties assume that read and write strobes are never both high in one cycle. They also assume that the address stays within the five-bit map and that event inputs are sampled only at clock edges, with no meaning given to their level between edges. The stimulus drives every input on the falling edge and samples results before the next rising edge. It issues at most one register access per cycle. It places event pulses either in quiet cycles or deliberately on the same edge as a clear, to exercise the collision rule.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;
  localparam int OFF_W  = 3;
  localparam int NBANK  = 3;

  // slot indices (upper address bits); summary bit order follows bank index
  localparam int SLOT_RX   = 0;
  localparam int SLOT_TX   = 1;
  localparam int SLOT_MISC = 2;
  localparam int SLOT_SUM  = 3;

  // bank register offsets
  localparam logic [OFF_W-1:0] OFF_CAUSE = 3'd0;
  localparam logic [OFF_W-1:0] OFF_MSET  = 3'd1;
  localparam logic [OFF_W-1:0] OFF_MCLR  = 3'd2;
  localparam logic [OFF_W-1:0] OFF_MVAL  = 3'd3;
  localparam logic [OFF_W-1:0] OFF_MODE  = 3'd4;

  // summary register offsets
  localparam logic [OFF_W-1:0] OFF_SCAUSE = 3'd0;
  localparam logic [OFF_W-1:0] OFF_SMASK  = 3'd1;

  // event bit positions
  localparam int RX_DONE_BIT  = 0;
  localparam int RX_HITHR_BIT = 1;
  localparam int TX_RING_N    = 25;
  localparam int TX_DONE_BIT  = TX_RING_N;
  localparam int MISC_RDY_BIT = 0;
  localparam int MISC_MBX_BIT = 1;
  localparam int MISC_ERR_BIT = 2;
endpackage

// File: rtl/irqc_bank.sv
module irqc_bank
  import irqc_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int OW = OFF_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] evt_i,
  input  logic          sel_i,
  input  logic          rd_en_i,
  input  logic          wr_en_i,
  input  logic [OW-1:0] off_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          pend_o,
  output logic [DW-1:0] cause_o,
  output logic [DW-1:0] mask_o,
  output logic          cor_o
);
  logic [DW-1:0] cause_q, cause_d, mask_q, mask_d, mode_q, mode_d, clr;
  logic cause_en, mask_en, mode_en, cor;
  logic rd_cause, wr_cause, wr_mset, wr_mclr, wr_mode;

  assign cor      = &mode_q;
  assign rd_cause = sel_i && rd_en_i && (off_i == OFF_CAUSE);
  assign wr_cause = sel_i && wr_en_i && (off_i == OFF_CAUSE);
  assign wr_mset  = sel_i && wr_en_i && (off_i == OFF_MSET);
  assign wr_mclr  = sel_i && wr_en_i && (off_i == OFF_MCLR);
  assign wr_mode  = sel_i && wr_en_i && (off_i == OFF_MODE);

  // next state
  always_comb begin
    clr = '0;
    if (cor && rd_cause)        clr = '1;
    else if (!cor && wr_cause)  clr = wdata_i;
    // new events override any clear on the same edge
    cause_d  = evt_i | (cause_q & ~clr);
    cause_en = (|evt_i) || (|clr);

    mask_d = mask_q;
    if (wr_mset)      mask_d = mask_q | wdata_i;
    else if (wr_mclr) mask_d = mask_q & ~wdata_i;
    mask_en = wr_mset || wr_mclr;

    mode_d  = wdata_i;
    mode_en = wr_mode;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= '1;
      mode_q  <= '0;
    end else begin
      if (cause_en) cause_q <= cause_d;
      if (mask_en)  mask_q  <= mask_d;
      if (mode_en)  mode_q  <= mode_d;
    end
  end

  always_comb begin
    case (off_i)
      OFF_CAUSE: rdata_o = cause_q;
      OFF_MVAL:  rdata_o = mask_q;
      OFF_MODE:  rdata_o = mode_q;
      default:   rdata_o = '0;
    endcase
  end

  assign pend_o  = |(cause_q & ~mask_q);
  assign cause_o = cause_q;
  assign mask_o  = mask_q;
  assign cor_o   = cor;
endmodule

// File: rtl/irqc_summary.sv
module irqc_summary
  import irqc_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int OW = OFF_W,
  parameter int NB = NBANK
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] pend_i,
  input  logic          sel_i,
  input  logic          rd_en_i,
  input  logic          wr_en_i,
  input  logic [OW-1:0] off_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic [NB-1:0] sum_o,
  output logic [DW-1:0] smask_o
);
  logic [NB-1:0] sum_q, sum_d;
  logic [DW-1:0] smask_q;
  logic rd_sum, wr_smask, sum_en;

  assign rd_sum   = sel_i && rd_en_i && (off_i == OFF_SCAUSE);
  assign wr_smask = sel_i && wr_en_i && (off_i == OFF_SMASK);

  always_comb begin
    sum_d  = pend_i | (rd_sum ? '0 : sum_q);
    sum_en = rd_sum || (|pend_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q   <= '0;
      smask_q <= '1;
    end else begin
      if (sum_en)   sum_q   <= sum_d;
      if (wr_smask) smask_q <= wdata_i;
    end
  end

  always_comb begin
    case (off_i)
      OFF_SCAUSE: rdata_o = {{(DW-NB){1'b0}}, sum_q};
      OFF_SMASK:  rdata_o = smask_q;
      default:    rdata_o = '0;
    endcase
  end

  assign irq_o   = |(sum_q & ~smask_q[NB-1:0]);
  assign sum_o   = sum_q;
  assign smask_o = smask_q;
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
  import irqc_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] rx_evt_i,
  input  logic [DW-1:0] tx_evt_i,
  input  logic [DW-1:0] misc_evt_i,
  output logic          irq_o
);
  localparam int SW = AW - OFF_W;

  // reset: asserted asynchronously, released after two edges
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic [SW-1:0]              slot;
  logic [OFF_W-1:0]           off;
  logic [NBANK-1:0][DW-1:0]   evt_all, bank_rd, cause_w, mask_w;
  logic [NBANK-1:0]           pend_w, cor_w, sum_w;
  logic [DW-1:0]              sum_rd, smask_w;

  assign slot    = addr_i[AW-1:OFF_W];
  assign off     = addr_i[OFF_W-1:0];
  assign evt_all = {misc_evt_i, tx_evt_i, rx_evt_i};

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    irqc_bank #(.DW(DW), .OW(OFF_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .evt_i   (evt_all[b]),
      .sel_i   (slot == SW'(b)),
      .rd_en_i (rd_en_i),
      .wr_en_i (wr_en_i),
      .off_i   (off),
      .wdata_i (wdata_i),
      .rdata_o (bank_rd[b]),
      .pend_o  (pend_w[b]),
      .cause_o (cause_w[b]),
      .mask_o  (mask_w[b]),
      .cor_o   (cor_w[b])
    );
  end

  irqc_summary #(.DW(DW), .OW(OFF_W), .NB(NBANK)) u_sum (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .pend_i  (pend_w),
    .sel_i   (slot == SW'(SLOT_SUM)),
    .rd_en_i (rd_en_i),
    .wr_en_i (wr_en_i),
    .off_i   (off),
    .wdata_i (wdata_i),
    .rdata_o (sum_rd),
    .irq_o   (irq_o),
    .sum_o   (sum_w),
    .smask_o (smask_w)
  );

  always_comb begin
    rdata_o = '0;
    if (slot == SW'(SLOT_SUM)) rdata_o = sum_rd;
    else if (slot < SW'(NBANK)) begin
      for (int b = 0; b < NBANK; b++)
        if (slot == SW'(b)) rdata_o = bank_rd[b];
    end
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    rd_en_i,
  input logic                    wr_en_i,
  input logic [AW-1:0]           addr_i,
  input logic [DW-1:0]           wdata_i,
  input logic [DW-1:0]           rx_evt_i,
  input logic                    irq_o,
  input logic [NBANK-1:0][DW-1:0] cause_w,
  input logic [NBANK-1:0][DW-1:0] mask_w,
  input logic [NBANK-1:0]        cor_w,
  input logic [NBANK-1:0]        pend_w,
  input logic [NBANK-1:0]        sum_w,
  input logic [DW-1:0]           smask_w
);
  localparam int SW = AW - OFF_W;
  localparam logic [AW-1:0] A_RX_CAUSE = {SW'(SLOT_RX), OFF_CAUSE};
  localparam logic [AW-1:0] A_RX_MSET  = {SW'(SLOT_RX), OFF_MSET};
  localparam logic [AW-1:0] A_SUM      = {SW'(SLOT_SUM), OFF_SCAUSE};

  a_r2_evt_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (|rx_evt_i) |=> ((cause_w[0] & $past(rx_evt_i)) == $past(rx_evt_i)));

  a_r3_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == A_RX_MSET) |=> ((mask_w[0] & $past(wdata_i)) == $past(wdata_i)));

  a_r4_w1c_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == A_RX_CAUSE && !cor_w[0])
      |=> ((cause_w[0] & $past(cause_w[0])) == $past(cause_w[0])));

  a_r5_cor_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == A_RX_CAUSE && cor_w[0] && rx_evt_i == '0) |=> (cause_w[0] == '0));

  a_r7_sum_follows_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend_w) |=> ((sum_w & $past(pend_w)) == $past(pend_w)));

  a_r8_sum_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == A_SUM && pend_w == '0) |=> (sum_w == '0));

  a_r9_irq_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (&smask_w[NBANK-1:0]) |-> !irq_o);
endmodule

bind irq_cause_ctrl irqc_checker #(.DW(DW), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .rd_en_i  (rd_en_i),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rx_evt_i (rx_evt_i),
  .irq_o    (irq_o),
  .cause_w  (cause_w),
  .mask_w   (mask_w),
  .cor_w    (cor_w),
  .pend_w   (pend_w),
  .sum_w    (sum_w),
  .smask_w  (smask_w)
);

// File: tb/irq_cause_ctrl_tb.sv
module irq_cause_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  localparam logic [1:0] K_NOP = 2'd0, K_WR = 2'd1, K_RD = 2'd2;
  localparam logic [1:0] E_RX = 2'd0, E_TX = 2'd1, E_MI = 2'd2, E_NO = 2'd3;

  typedef struct packed {
    logic [1:0]  kind;
    logic [4:0]  addr;
    logic [31:0] wdata;
    logic [1:0]  ebank;
    logic [31:0] evt;
    logic [31:0] exp_rd;
    logic        exp_irq;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 45;
  localparam vec_t VEC [NV] = '{
    '{K_RD,  5'h03, 32'h0,        E_NO, 32'h0,        32'hFFFFFFFF, 1'b0, 8'd1},  // R1 rx mask
    '{K_RD,  5'h0C, 32'h0,        E_NO, 32'h0,        32'h0,        1'b0, 8'd1},  // R1 tx mode
    '{K_RD,  5'h19, 32'h0,        E_NO, 32'h0,        32'hFFFFFFFF, 1'b0, 8'd1},  // R1 summary mask
    '{K_RD,  5'h18, 32'h0,        E_NO, 32'h0,        32'h0,        1'b0, 8'd1},  // R1 summary
    '{K_NOP, 5'h00, 32'h0,        E_RX, 32'h3,        32'h0,        1'b0, 8'd2},  // R2 done+hithr
    '{K_RD,  5'h00, 32'h0,        E_NO, 32'h0,        32'h3,        1'b0, 8'd10}, // R10 masked but latched
    '{K_WR,  5'h02, 32'h1,        E_NO, 32'h0,        32'h0,        1'b0, 8'd3},  // R3 mask clear
    '{K_RD,  5'h03, 32'h0,        E_NO, 32'h0,        32'hFFFFFFFE, 1'b0, 8'd3},
    '{K_NOP, 5'h00, 32'h0,        E_NO, 32'h0,        32'h0,        1'b0, 8'd9},  // R9 blocked
    '{K_WR,  5'h19, 32'hFFFFFFF8, E_NO, 32'h0,        32'h0,        1'b0, 8'd9},
    '{K_NOP, 5'h00, 32'h0,        E_NO, 32'h0,        32'h0,        1'b1, 8'd9},  // R9 enabled
    '{K_WR,  5'h00, 32'h1,        E_NO, 32'h0,        32'h0,        1'b1, 8'd4},  // R4 w1c
    '{K_RD,  5'h00, 32'h0,        E_NO, 32'h0,        32'h2,        1'b1, 8'd4},
    '{K_RD,  5'h18, 32'h0,        E_NO, 32'h0,        32'h1,        1'b1, 8'd8},  // R8 read summary
    '{K_RD,  5'h00, 32'h0,        E_NO, 32'h0,        32'h2,        1'b0, 8'd4},  // R4 read kept
    '{K_WR,  5'h04, 32'hFFFFFFFF, E_NO, 32'h0,        32'h0,        1'b0, 8'd5},  // R5 cor mode
    '{K_RD,  5'h04, 32'h0,        E_NO, 32'h0,        32'hFFFFFFFF, 1'b0, 8'd5},
    '{K_WR,  5'h00, 32'h2,        E_NO, 32'h0,        32'h0,        1'b0, 8'd5},  // R5 write ignored
    '{K_RD,  5'h00, 32'h0,        E_NO, 32'h0,        32'h2,        1'b0, 8'd5},
    '{K_RD,  5'h00, 32'h0,        E_NO, 32'h0,        32'h0,        1'b0, 8'd5},  // R5 cleared
    '{K_NOP, 5'h00, 32'h0,        E_TX, 32'h03000001, 32'h0,        1'b0, 8'd10}, // R10 rings+done
    '{K_WR,  5'h0A, 32'h02000000, E_NO, 32'h0,        32'h0,        1'b0, 8'd3},
    '{K_RD,  5'h08, 32'h0,        E_NO, 32'h0,        32'h03000001, 1'b0, 8'd10},
    '{K_NOP, 5'h00, 32'h0,        E_NO, 32'h0,        32'h0,        1'b1, 8'd7},  // R7 tx summary
    '{K_RD,  5'h18, 32'h0,        E_NO, 32'h0,        32'h2,        1'b1, 8'd7},
    '{K_RD,  5'h18, 32'h0,        E_NO, 32'h0,        32'h2,        1'b1, 8'd8},  // R8 still pending
    '{K_WR,  5'h08, 32'hFFFFFFFF, E_NO, 32'h0,        32'h0,        1'b1, 8'd4},
    '{K_RD,  5'h18, 32'h0,        E_NO, 32'h0,        32'h2,        1'b1, 8'd8},
    '{K_RD,  5'h08, 32'h0,        E_NO, 32'h0,        32'h0,        1'b0, 8'd8},
    '{K_WR,  5'h14, 32'hFFFFFFFF, E_NO, 32'h0,        32'h0,        1'b0, 8'd5},
    '{K_NOP, 5'h00, 32'h0,        E_MI, 32'h4,        32'h0,        1'b0, 8'd10}, // R10 error
    '{K_RD,  5'h10, 32'h0,        E_MI, 32'h2,        32'h4,        1'b0, 8'd6},  // R6 read+event
    '{K_RD,  5'h10, 32'h0,        E_NO, 32'h0,        32'h2,        1'b0, 8'd6},
    '{K_WR,  5'h14, 32'h0,        E_NO, 32'h0,        32'h0,        1'b0, 8'd4},
    '{K_NOP, 5'h00, 32'h0,        E_MI, 32'h1,        32'h0,        1'b0, 8'd2},
    '{K_WR,  5'h10, 32'h1,        E_MI, 32'h1,        32'h0,        1'b0, 8'd6},  // R6 w1c+event
    '{K_RD,  5'h10, 32'h0,        E_NO, 32'h0,        32'h1,        1'b0, 8'd6},
    '{K_WR,  5'h12, 32'h7,        E_NO, 32'h0,        32'h0,        1'b0, 8'd3},
    '{K_RD,  5'h13, 32'h0,        E_NO, 32'h0,        32'hFFFFFFF8, 1'b0, 8'd3},
    '{K_WR,  5'h11, 32'h1,        E_NO, 32'h0,        32'h0,        1'b1, 8'd3},  // R3 mask set
    '{K_RD,  5'h13, 32'h0,        E_NO, 32'h0,        32'hFFFFFFF9, 1'b1, 8'd3},
    '{K_RD,  5'h18, 32'h0,        E_NO, 32'h0,        32'h4,        1'b1, 8'd7},  // R7 misc summary
    '{K_RD,  5'h1F, 32'h0,        E_NO, 32'h0,        32'h0,        1'b0, 8'd11}, // R11 unmapped
    '{K_WR,  5'h19, 32'hFFFFFFFF, E_NO, 32'h0,        32'h0,        1'b0, 8'd9},
    '{K_RD,  5'h19, 32'h0,        E_NO, 32'h0,        32'hFFFFFFFF, 1'b0, 8'd9}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_en, wr_en;
  logic [4:0]  addr;
  logic [31:0] wdata, rdata, rx_evt, tx_evt, misc_evt;
  logic        irq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_cause_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .rd_en_i(rd_en), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .rx_evt_i(rx_evt), .tx_evt_i(tx_evt), .misc_evt_i(misc_evt), .irq_o(irq)
  );

  task automatic idle_inputs();
    rd_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    rx_evt = '0; tx_evt = '0; misc_evt = '0;
  endtask

  // drive on the falling edge, sample a quarter period later, before the rising edge
  task automatic apply(input vec_t v);
    @(negedge clk);
    idle_inputs();
    rd_en = (v.kind == K_RD);
    wr_en = (v.kind == K_WR);
    addr  = v.addr;
    wdata = v.wdata;
    case (v.ebank)
      E_RX:    rx_evt   = v.evt;
      E_TX:    tx_evt   = v.evt;
      E_MI:    misc_evt = v.evt;
      default: ;
    endcase
    #(CLK_PERIOD/4);
    n_chk++;
    if ((v.kind == K_RD && rdata !== v.exp_rd) || irq !== v.exp_irq) begin
      n_bad++;
      $display("FAIL R%0d addr=%h rdata=%h exp=%h irq=%b exp_irq=%b",
               v.req, v.addr, rdata, v.exp_rd, irq, v.exp_irq);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    do_reset();
    for (int i = 0; i < NV; i++) apply(VEC[i]);

    // R1: reset in the middle of activity returns everything to its reset value
    apply('{K_NOP, 5'h00, 32'h0, E_RX, 32'h1, 32'h0, 1'b0, 8'd1});
    do_reset();
    apply('{K_RD, 5'h00, 32'h0, E_NO, 32'h0, 32'h0,        1'b0, 8'd1}); // R1 cause
    apply('{K_RD, 5'h03, 32'h0, E_NO, 32'h0, 32'hFFFFFFFF, 1'b0, 8'd1}); // R1 mask
    apply('{K_RD, 5'h04, 32'h0, E_NO, 32'h0, 32'h0,        1'b0, 8'd1}); // R1 mode
    apply('{K_RD, 5'h19, 32'h0, E_NO, 32'h0, 32'hFFFFFFFF, 1'b0, 8'd1}); // R1 summary mask
    // R11: read data reflects the value before the read's own clearing
    apply('{K_WR, 5'h0C, 32'hFFFFFFFF, E_NO, 32'h0, 32'h0, 1'b0, 8'd11});
    apply('{K_NOP, 5'h00, 32'h0, E_TX, 32'h00000100, 32'h0, 1'b0, 8'd11});
    apply('{K_RD, 5'h08, 32'h0, E_NO, 32'h0, 32'h00000100, 1'b0, 8'd11});
    apply('{K_RD, 5'h08, 32'h0, E_NO, 32'h0, 32'h0,        1'b0, 8'd11});

    @(negedge clk);
    idle_inputs();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule